// File: doc/BRIEF.md
# Memory Calibration Retry Sequencer

This block supervises the bring-up of an external memory interface. After a start pulse it watches a calibration-success status line. It looks at that line only once per poll interval, where the interval is a number of ticks of a slow time base (`tick_i`). If a fixed number of looks all find calibration still pending, the block resets the interface's sequencer through a pair of 4-bit mailboxes, one per direction. It then begins a new attempt. After a fixed number of attempts without success it declares failure.

The reset handshake has up to three waits, and each one is bounded by a count of ticks:

- **Stale clear.** This step runs only if the inbound mailbox already shows bits when the handshake begins. The outbound mailbox is held at zero until the inbound one goes quiet.
- **Request.** The outbound mailbox is driven to all ones. The block then waits for the sequencer to drop inbound bit 3.
- **Closing clear.** The outbound mailbox returns to zero, and the block waits for the inbound mailbox to go quiet.

If any wait runs out, the handshake is abandoned. A failed handshake does not end the sequence: the next attempt still runs, and only the attempt limit raises failure.

The tick period and every count are parameters. A simulation can shrink them without changing the behaviour.

States:

| State | Role |
|---|---|
| `ST_IDLE` | Waits for a start pulse. |
| `ST_CAL_WAIT` | Counts ticks and samples the status line. |
| `ST_HS_CHECK` | Decides whether the stale clear is needed. |
| `ST_PRE_CLR` | Stale clear. |
| `ST_REQ` | Request. |
| `ST_POST_CLR` | Closing clear. |
| `ST_NEXT` | Decides between another attempt and failure. |
| `ST_DONE` | Terminal state after success. |
| `ST_FAIL` | Terminal state after the attempt limit. |

Transitions:

| From | To | Condition |
|---|---|---|
| `ST_IDLE`, `ST_DONE`, `ST_FAIL` | `ST_CAL_WAIT` | Start pulse. |
| `ST_CAL_WAIT` | `ST_DONE` | A sample reads success. |
| `ST_CAL_WAIT` | `ST_HS_CHECK` | Last permitted sample reads failure. |
| `ST_HS_CHECK` | `ST_PRE_CLR` | Inbound mailbox is non-zero. |
| `ST_HS_CHECK` | `ST_REQ` | Inbound mailbox is zero. |
| `ST_PRE_CLR` | `ST_REQ` | Inbound mailbox goes quiet. |
| `ST_PRE_CLR` | `ST_NEXT` | Clear timeout. |
| `ST_REQ` | `ST_POST_CLR` | Acknowledge seen. |
| `ST_REQ` | `ST_NEXT` | Acknowledge timeout. |
| `ST_POST_CLR` | `ST_NEXT` | Inbound mailbox goes quiet, or timeout. |
| `ST_NEXT` | `ST_CAL_WAIT` | Attempts remain. |
| `ST_NEXT` | `ST_FAIL` | Attempt limit reached. |

Top module: `cal_retry_seq`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `fail_o`, `busy_o` and `wdog_kick_o` are 0, `attempts_o` is 0, and `mbox_out_o` is 4'h0.
- R2: A start pulse accepted while not busy clears `done_o` and `fail_o` and sets `attempts_o` to 1. The following cycle shows `busy_o` high and a single-cycle `wdog_kick_o` pulse. Every later attempt begins with another single-cycle kick.
- R3: The status line `cal_ok_i` is sampled only on the POLL_GAP-th tick after the previous sample or after the attempt begins. Its value in any other cycle has no effect. A high sample sets `done_o` from the next cycle and drops `busy_o`, and `done_o` holds until the next accepted start.
- R4: When CAL_POLLS samples of one attempt are all low, the handshake begins. If the inbound mailbox `mbox_in_i` is non-zero at that point, the stale-clear phase runs first with `mbox_out_o` = 4'h0.
- R5: A clear phase (stale or closing) checks on each tick whether `mbox_in_i` equals 4'h0. If it is still non-zero on the CLR_SLOTS-th tick, the phase times out. A stale-clear timeout abandons the handshake without ever driving a request.
- R6: The request phase drives `mbox_out_o` = 4'hF and checks on each tick whether `mbox_in_i` bit 3 is 0. If the bit is still 1 on the ACK_SLOTS-th tick, the handshake is abandoned.
- R7: After the acknowledge, `mbox_out_o` returns to 4'h0 and the closing clear runs with the rules of R5.
- R8: A completed or abandoned handshake leads to the next attempt, which increments `attempts_o` while attempts remain. `attempts_o` never exceeds CAL_ATTEMPTS.
- R9: When attempt CAL_ATTEMPTS ends its handshake, `fail_o` rises, `busy_o` falls, and `attempts_o` holds CAL_ATTEMPTS. `fail_o` holds until the next accepted start.
- R10: `mbox_out_o` only ever carries 4'h0 or 4'hF, and `done_o` and `fail_o` are never high together.
- R11: A start pulse while `busy_o` is high is ignored. The running sequence, including its attempt count, continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when not busy |
| tick_i | input | 1 | Single-cycle time-base strobe for all polls and waits |
| cal_ok_i | input | 1 | Calibration-success status from the interface |
| mbox_in_i | input | 4 | Sequencer-to-core mailbox |
| mbox_out_o | output | 4 | Core-to-sequencer mailbox (4'h0 or 4'hF) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sticky success flag |
| fail_o | output | 1 | Sticky failure flag |
| attempts_o | output | ATT_W (2) | Attempts used in the current or last sequence |
| wdog_kick_o | output | 1 | One-cycle pulse at the start of each attempt |

## Verification
The bound checker watches the following on every cycle:

- the two legal mailbox codes;
- the mutual exclusion of the result flags;
- the stickiness of `done_o`;
- the single-cycle width of the kick;
- the cap on the attempt count, and that the count never falls while busy;
- the pairing of failure with a full attempt count.

Some behaviour depends on tick timing and on how the sequencer responds, and only the bench scenarios can show it. This covers:

- which tick actually samples the status;
- the choice of the stale-clear path;
- each timeout landing on the right tick;
- an abandoned handshake still leading to a new attempt;
- a start pulse during a run being ignored.

The bench's cycle model covers all of these with stale mailbox bits, a stuck acknowledge bit, a slow acknowledge and status glitches between samples.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CAL_WAIT,
        ST_HS_CHECK,
        ST_PRE_CLR,
        ST_REQ,
        ST_POST_CLR,
        ST_NEXT,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    localparam int          MBOX_W    = 4;
    localparam int          ACK_BIT   = 3;
    localparam logic [3:0]  MBOX_QUIET = 4'h0;
    localparam logic [3:0]  MBOX_RESET = 4'hF;

endpackage

// File: rtl/cal_tick_counter.sv
// Up-counter with synchronous clear; flags the count that precedes the limit.
module cal_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] lim,
    output logic         last
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == lim - 1'b1);

endmodule

// File: rtl/cal_mbox_decode.sv
// Decodes the inbound mailbox into the two conditions the sequencer needs.
module cal_mbox_decode
    import cal_seq_pkg::*;
(
    input  logic [MBOX_W-1:0] mbox_in,
    output logic              quiet,
    output logic              acked
);

    assign quiet = (mbox_in == MBOX_QUIET);
    assign acked = ~mbox_in[ACK_BIT];

endmodule

// File: rtl/cal_retry_seq.sv
module cal_retry_seq
    import cal_seq_pkg::*;
#(
    parameter int CAL_ATTEMPTS = 3,
    parameter int CAL_POLLS    = 10,
    parameter int POLL_GAP     = 5000,
    parameter int CLR_SLOTS    = 1048576,
    parameter int ACK_SLOTS    = 10000,
    localparam int ATT_W       = $clog2(CAL_ATTEMPTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic              cal_ok_i,
    input  logic [3:0]        mbox_in_i,
    output logic [3:0]        mbox_out_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [ATT_W-1:0]  attempts_o,
    output logic              wdog_kick_o
);

    localparam int GAP_W    = $clog2(POLL_GAP + 1);
    localparam int POLL_W   = $clog2(CAL_POLLS + 1);
    localparam int SLOT_MAX = (CLR_SLOTS > ACK_SLOTS) ? CLR_SLOTS : ACK_SLOTS;
    localparam int SLOT_W   = $clog2(SLOT_MAX + 1);

    seq_state_t state_q, state_d;

    logic gap_last, poll_last, slot_last;
    logic mb_quiet, mb_acked;
    logic in_hs, sample, chg, idle_like;
    logic [SLOT_W-1:0] slot_lim;

    logic [ATT_W-1:0] att_q;
    logic done_q, fail_q, kick_q;

    assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);
    assign in_hs     = (state_q == ST_PRE_CLR) || (state_q == ST_REQ) || (state_q == ST_POST_CLR);
    assign sample    = (state_q == ST_CAL_WAIT) && tick_i && gap_last;
    assign chg       = (state_d != state_q);
    assign slot_lim  = (state_q == ST_REQ) ? SLOT_W'(ACK_SLOTS) : SLOT_W'(CLR_SLOTS);

    cal_mbox_decode u_decode (
        .mbox_in (mbox_in_i),
        .quiet   (mb_quiet),
        .acked   (mb_acked)
    );

    cal_tick_counter #(.W(GAP_W)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (chg || sample),
        .inc   (tick_i && (state_q == ST_CAL_WAIT)),
        .lim   (GAP_W'(POLL_GAP)),
        .last  (gap_last)
    );

    cal_tick_counter #(.W(POLL_W)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (chg),
        .inc   (sample),
        .lim   (POLL_W'(CAL_POLLS)),
        .last  (poll_last)
    );

    cal_tick_counter #(.W(SLOT_W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (chg),
        .inc   (tick_i && in_hs),
        .lim   (slot_lim),
        .last  (slot_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start_i) state_d = ST_CAL_WAIT;
            end
            ST_CAL_WAIT: begin
                if (sample) begin
                    if (cal_ok_i)       state_d = ST_DONE;
                    else if (poll_last) state_d = ST_HS_CHECK;
                end
            end
            ST_HS_CHECK: begin
                state_d = mb_quiet ? ST_REQ : ST_PRE_CLR;
            end
            ST_PRE_CLR: begin
                if (tick_i) begin
                    if (mb_quiet)       state_d = ST_REQ;
                    else if (slot_last) state_d = ST_NEXT;
                end
            end
            ST_REQ: begin
                if (tick_i) begin
                    if (mb_acked)       state_d = ST_POST_CLR;
                    else if (slot_last) state_d = ST_NEXT;
                end
            end
            ST_POST_CLR: begin
                if (tick_i && (mb_quiet || slot_last)) state_d = ST_NEXT;
            end
            ST_NEXT: begin
                state_d = (att_q == ATT_W'(CAL_ATTEMPTS)) ? ST_FAIL : ST_CAL_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            att_q  <= '0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
            kick_q <= 1'b0;
        end else begin
            kick_q <= (state_d == ST_CAL_WAIT) && (state_q != ST_CAL_WAIT);
            if (idle_like && start_i) begin
                att_q  <= ATT_W'(1);
                done_q <= 1'b0;
                fail_q <= 1'b0;
            end else begin
                if (state_q == ST_NEXT && state_d == ST_CAL_WAIT) att_q <= att_q + 1'b1;
                if (state_q == ST_CAL_WAIT && state_d == ST_DONE) done_q <= 1'b1;
                if (state_q == ST_NEXT && state_d == ST_FAIL)     fail_q <= 1'b1;
            end
        end
    end

    assign mbox_out_o  = (state_q == ST_REQ) ? MBOX_RESET : MBOX_QUIET;
    assign busy_o      = !idle_like;
    assign done_o      = done_q;
    assign fail_o      = fail_q;
    assign attempts_o  = att_q;
    assign wdog_kick_o = kick_q;

endmodule

// File: rtl/cal_retry_seq_chk.sv
module cal_retry_seq_chk #(
    parameter int CAL_ATTEMPTS = 3,
    parameter int ATT_W        = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [3:0]       mbox_out_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             fail_o,
    input logic [ATT_W-1:0] attempts_o,
    input logic             wdog_kick_o
);

    assert_mbox_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_out_o == 4'h0) || (mbox_out_o == 4'hF));

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    assert_kick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_kick_o |=> !wdog_kick_o);

    assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    assert_fail_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (attempts_o == ATT_W'(CAL_ATTEMPTS)));

    assert_att_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        attempts_o <= ATT_W'(CAL_ATTEMPTS));

    assert_req_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_out_o != 4'h0) |-> busy_o);

    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (attempts_o >= $past(attempts_o)));

endmodule

bind cal_retry_seq cal_retry_seq_chk #(
    .CAL_ATTEMPTS (CAL_ATTEMPTS),
    .ATT_W        (ATT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mbox_out_o  (mbox_out_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .attempts_o  (attempts_o),
    .wdog_kick_o (wdog_kick_o)
);

// File: tb/cal_retry_seq_tb.sv
`timescale 1ns/1ps
module cal_retry_seq_tb;

    localparam int ATT  = 3;
    localparam int POLLS = 10;
    localparam int GAP  = 3;
    localparam int CLR  = 8;
    localparam int ACK  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic tick_i = 1'b0;
    logic cal_ok_i = 1'b0;
    logic [3:0] mbox_in_i = 4'h0;
    logic [3:0] mbox_out_o;
    logic busy_o, done_o, fail_o, wdog_kick_o;
    logic [1:0] attempts_o;

    always #5 clk = ~clk;

    cal_retry_seq #(
        .CAL_ATTEMPTS(ATT), .CAL_POLLS(POLLS), .POLL_GAP(GAP),
        .CLR_SLOTS(CLR), .ACK_SLOTS(ACK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
        .cal_ok_i(cal_ok_i), .mbox_in_i(mbox_in_i), .mbox_out_o(mbox_out_o),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .attempts_o(attempts_o), .wdog_kick_o(wdog_kick_o)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int scn_cyc = 0;
    int kicks = 0;
    int reqs = 0;

    // scenario knobs
    int ok_att = 0;
    int ok_after = 0;
    bit glitch = 0;
    bit stuck = 0;
    int stale_len = 0;
    int ack_delay = 0;
    int req_seen = 0;
    bit start_req = 0;

    // behavioural reference: phase codes 0 idle,1 wait,2 check,3 preclr,4 req,5 postclr,6 next,7 done,8 fail
    int ms, mg, mp, msl, ma, ns;
    bit md, mf, mk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms = 0; mg = 0; mp = 0; msl = 0; ma = 0; md = 0; mf = 0; mk = 0;
        end else begin
            ns = ms;
            case (ms)
                0, 7, 8: if (start_i) begin
                    ns = 1; md = 0; mf = 0; ma = 1; mg = 0; mp = 0;
                end
                1: if (tick_i) begin
                    mg++;
                    if (mg == GAP) begin
                        mg = 0;
                        if (cal_ok_i) begin ns = 7; md = 1; end
                        else begin mp++; if (mp == POLLS) ns = 2; end
                    end
                end
                2: begin ns = (mbox_in_i != 0) ? 3 : 4; msl = 0; end
                3: if (tick_i) begin
                    if (mbox_in_i == 0) begin ns = 4; msl = 0; end
                    else begin msl++; if (msl == CLR) ns = 6; end
                end
                4: if (tick_i) begin
                    if (!mbox_in_i[3]) begin ns = 5; msl = 0; end
                    else begin msl++; if (msl == ACK) ns = 6; end
                end
                5: if (tick_i) begin
                    if (mbox_in_i == 0) ns = 6;
                    else begin msl++; if (msl == CLR) ns = 6; end
                end
                6: if (ma == ATT) begin ns = 8; mf = 1; end
                   else begin ma++; ns = 1; mg = 0; mp = 0; end
                default: ns = 0;
            endcase
            mk = (ns == 1) && (ms != 1);
            ms = ns;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        logic [3:0] e_c2s;
        bit e_busy;
        e_c2s  = (ms == 4) ? 4'hF : 4'h0;
        e_busy = (ms >= 1) && (ms <= 6);
        check(mbox_out_o == e_c2s, "R6 mailbox", int'(mbox_out_o), int'(e_c2s));
        check(done_o == md, "R3 done", int'(done_o), int'(md));
        check(fail_o == mf, "R9 fail", int'(fail_o), int'(mf));
        check(int'(attempts_o) == ma, "R8 attempts", int'(attempts_o), ma);
        check(wdog_kick_o == mk, "R2 kick", int'(wdog_kick_o), int'(mk));
        check(busy_o == e_busy, "R11 busy", int'(busy_o), int'(e_busy));
    endtask

    task automatic step();
        @(negedge clk);
        cyc++; scn_cyc++;
        if (rst_n) compare_all();
        if (wdog_kick_o) kicks++;
        if (mbox_out_o == 4'hF) reqs++;
        start_i = start_req;
        start_req = 0;
        tick_i = (cyc % 2) == 0;
        if (glitch) cal_ok_i = !tick_i;
        else cal_ok_i = (ok_att != 0) && (int'(attempts_o) == ok_att) && (scn_cyc > ok_after);
        if (stuck) mbox_in_i = 4'h8;
        else if (scn_cyc < stale_len) mbox_in_i = 4'h2;
        else if (mbox_out_o == 4'hF) begin
            mbox_in_i = (req_seen < ack_delay) ? 4'h8 : 4'h0;
            req_seen++;
        end else begin
            mbox_in_i = 4'h0;
            req_seen = 0;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic new_scn(input int oa, input int oaft, input bit gl, input bit st,
                           input int stl, input int ackd);
        ok_att = oa; ok_after = oaft; glitch = gl; stuck = st;
        stale_len = stl; ack_delay = ackd; req_seen = 0;
        scn_cyc = 0; kicks = 0; reqs = 0;
        start_req = 1;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        run(3);
        // R1: outputs during and after reset
        check(!busy_o && !done_o && !fail_o && !wdog_kick_o, "R1 flags in reset", int'(busy_o), 0);
        check(attempts_o == 0 && mbox_out_o == 0, "R1 count/mailbox in reset", int'(attempts_o), 0);
        rst_n = 1'b1;
        run(4);
        check(!busy_o && attempts_o == 0 && mbox_out_o == 0, "R1 after release", int'(busy_o), 0);

        // A: success on attempt 1
        new_scn(1, 20, 0, 0, 0, 2);
        run(120);
        check(done_o && !fail_o, "R3 done on first attempt", int'(done_o), 1);
        check(attempts_o == 1, "R3 attempts", int'(attempts_o), 1);
        check(kicks == 1, "R2 one kick", kicks, 1);

        // B: status glitches between samples only, fast ack -> fail after 3
        new_scn(0, 0, 1, 0, 0, 0);
        run(400);
        check(fail_o && !done_o, "R9 fail after all attempts (R3 glitches ignored)", int'(fail_o), 1);
        check(attempts_o == 3, "R9 attempt count", int'(attempts_o), 3);
        check(kicks == 3, "R2 kick per attempt", kicks, 3);
        check(reqs == 3, "R6 one request cycle per handshake", reqs, 3);

        // C: stale mailbox at first handshake, slow ack, success on attempt 2
        new_scn(2, 0, 0, 0, 70, 3);
        run(300);
        check(done_o && attempts_o == 2, "R4 R7 R8 stale clear then retry", int'(attempts_o), 2);
        check(reqs > 0, "R6 request driven", reqs, 1);

        // D: mailbox stuck busy -> stale clear times out, no request ever
        new_scn(0, 0, 0, 1, 0, 0);
        run(450);
        check(fail_o && attempts_o == 3, "R5 clear timeout still retries", int'(attempts_o), 3);
        check(reqs == 0, "R5 no request after clear timeout", reqs, 0);

        // E: ack never arrives, restart pulse while busy, success on attempt 3
        new_scn(3, 0, 0, 0, 0, 1000);
        run(100);
        start_req = 1;
        run(400);
        check(done_o && attempts_o == 3, "R11 start ignored while busy (R6 ack timeout)", int'(attempts_o), 3);
        check(kicks == 3, "R11 no extra kick", kicks, 3);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule